// File: doc/BRIEF.md
# Configurable Integer Min/Max Unit

This block picks the smaller or the larger of two XLEN-bit integer operands. A 3-bit mode field sets three things: whether only the low halves are compared or the whole words, whether the ordering is signed or unsigned, and whether the minimum or the maximum is returned. The block does not build a separate comparator for each mode. It prepares both operands and feeds them to one unsigned less-than comparator:

- In half-width mode, each operand's low half moves up into the high half and the vacated low half becomes zero.
- In signed mode, the top bit of each prepared operand is flipped.
- In maximum mode, the two prepared operands trade places before the compare.

The returned value is always one of the two original operands at full width, never the prepared copy.

A record flag requests a 4-bit condition field. This field reports whether the first operand is below, above or equal to the second, in the ordering the mode selects. Its lowest bit is a copy of an incoming summary-overflow bit. When the record flag is low, the condition output keeps its last value. A zero-register flag makes the first operand read as zero, both for the compare and for the returned value. A parameter adds an optional output register stage, which is enabled by default and carries a valid bit alongside the data.

Top module: `minmax_unit`

## Requirements
- R1: With mode = 3'b000 (bit 0 half-width, bit 1 signed, bit 2 maximum), the result is the unsigned minimum of the full-width operands. With mode = 3'b100 it is the unsigned maximum.
- R2: When mode bit 0 is set, only bits XLEN/2-1:0 of each operand take part in the comparison.
- R3: When mode bit 1 is set, the operands are ordered as two's-complement numbers: the full word, or the low half when mode bit 0 is also set.
- R4: When the compared values are equal, the result is the full second operand. This holds in both minimum and maximum mode.
- R5: The result is always one of the two original full-width operands, including in half-width mode.
- R6: When an accepted input has the record flag set, the condition output becomes {lt, gt, eq, so_in}. These compare the first operand against the second in the ordering the mode selects. Exactly one of bits 3..1 is set, and mode bit 2 has no effect on them.
- R7: When the record flag is clear, or no input is accepted, the condition output keeps its previous value.
- R8: When the zero-register flag is set, the first operand is treated as zero for both the comparison and the result.
- R9: With the output register enabled, out_valid and the matching result and condition appear one clock after in_valid is sampled high. out_valid is low after a cycle with no input.
- R10: After reset, out_valid, result and cond are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 3 | bit0 half-width, bit1 signed, bit2 maximum |
| rec_en | input | 1 | Update the condition output |
| ra_zero | input | 1 | Treat the first operand as zero |
| so_in | input | 1 | Summary-overflow bit copied into cond[0] |
| opa | input | XLEN | First operand |
| opb | input | XLEN | Second operand |
| out_valid | output | 1 | Result is valid |
| result | output | XLEN | Selected full-width operand |
| cond | output | 4 | {lt, gt, eq, so} |

## Verification
With the default output register, the result, the condition field and out_valid are due at the first rising edge after the one that samples in_valid high. The condition field must then stay unchanged until the next accepted input with the record flag set. The bench changes inputs on falling edges and reads outputs at the following falling edge, exactly one rising edge after the vector is presented. It then deasserts in_valid, or presents the next vector, so a held condition is observed across idle cycles and across non-recording vectors.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
   localparam int COND_W = 4;

   typedef struct packed {
      logic max_sel;
      logic signed_sel;
      logic half_sel;
   } mm_mode_t;

   localparam int CMP_RELATIONAL = 0;
   localparam int CMP_BORROW     = 1;
endpackage

// File: rtl/minmax_prep.sv
module minmax_prep #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] raw,
   input  logic            half_sel,
   input  logic            signed_sel,
   output logic [XLEN-1:0] prepared
);
   localparam int HALF = XLEN / 2;

   initial begin
      if (XLEN < 2 || (XLEN % 2) != 0)
         $error("minmax_prep: XLEN must be even and at least 2");
   end

   logic [XLEN-1:0] placed;

   always_comb begin
      if (half_sel)
         placed = {raw[HALF-1:0], {HALF{1'b0}}};
      else
         placed = raw;
      prepared = placed;
      prepared[XLEN-1] = placed[XLEN-1] ^ signed_sel;
   end

   always_comb begin
      if (half_sel)
         AST_HALF_LOW_ZERO: assert (prepared[HALF-1:0] == '0); // R2
   end
endmodule

// File: rtl/minmax_ucmp.sv
module minmax_ucmp #(
   parameter int XLEN = 64,
   parameter int IMPL = minmax_pkg::CMP_RELATIONAL
) (
   input  logic [XLEN-1:0] x,
   input  logic [XLEN-1:0] y,
   output logic            lt,
   output logic            eq
);
   initial begin
      if (IMPL != minmax_pkg::CMP_RELATIONAL && IMPL != minmax_pkg::CMP_BORROW)
         $error("minmax_ucmp: unknown IMPL");
   end

   generate
      if (IMPL == minmax_pkg::CMP_BORROW) begin : g_borrow
         logic [XLEN:0] diff;
         always_comb begin
            diff = {1'b0, x} - {1'b0, y};
            lt   = diff[XLEN];
         end
      end else begin : g_rel
         always_comb lt = (x < y);
      end
   endgenerate

   always_comb eq = (x == y);

   always_comb begin
      AST_LT_EQ_EXCL: assert (!(lt && eq)); // R6
   end
endmodule

// File: rtl/minmax_cond.sv
module minmax_cond (
   input  logic       cmp_lt,
   input  logic       cmp_eq,
   input  logic       max_sel,
   input  logic       so_in,
   output logic       pick_first,
   output logic [3:0] cond_new
);
   logic orig_lt, orig_gt;

   always_comb begin
      pick_first = cmp_lt;
      if (max_sel) begin
         orig_gt = cmp_lt;
         orig_lt = !cmp_lt && !cmp_eq;
      end else begin
         orig_lt = cmp_lt;
         orig_gt = !cmp_lt && !cmp_eq;
      end
      cond_new = {orig_lt, orig_gt, cmp_eq, so_in};
   end

   always_comb begin
      AST_COND_ONE_HOT: assert ($countones(cond_new[3:1]) == 1); // R6
   end
endmodule

// File: rtl/minmax_unit.sv
module minmax_unit #(
   parameter int XLEN     = 64,
   parameter bit REG_OUT  = 1'b1,
   parameter int CMP_IMPL = minmax_pkg::CMP_RELATIONAL
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [2:0]      mode,
   input  logic            rec_en,
   input  logic            ra_zero,
   input  logic            so_in,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic            out_valid,
   output logic [XLEN-1:0] result,
   output logic [3:0]      cond
);
   import minmax_pkg::*;

   initial begin
      if (XLEN < 2 || (XLEN % 2) != 0)
         $error("minmax_unit: XLEN must be even and at least 2");
   end

   mm_mode_t        md;
   logic [XLEN-1:0] opa_eff;
   logic [XLEN-1:0] prep_a, prep_b;
   logic [XLEN-1:0] cmp_x, cmp_y;
   logic            cmp_lt, cmp_eq, pick_first;
   logic [3:0]      cond_new;
   logic [XLEN-1:0] sel_comb;
   logic            cond_upd;
   logic [3:0]      cond_q;

   always_comb begin
      md      = mm_mode_t'(mode);
      opa_eff = ra_zero ? '0 : opa;
   end

   minmax_prep #(.XLEN(XLEN)) i_prep_a (
      .raw(opa_eff), .half_sel(md.half_sel), .signed_sel(md.signed_sel), .prepared(prep_a));
   minmax_prep #(.XLEN(XLEN)) i_prep_b (
      .raw(opb), .half_sel(md.half_sel), .signed_sel(md.signed_sel), .prepared(prep_b));

   always_comb begin
      cmp_x = md.max_sel ? prep_b : prep_a;
      cmp_y = md.max_sel ? prep_a : prep_b;
   end

   minmax_ucmp #(.XLEN(XLEN), .IMPL(CMP_IMPL)) i_cmp (
      .x(cmp_x), .y(cmp_y), .lt(cmp_lt), .eq(cmp_eq));

   minmax_cond i_cond (
      .cmp_lt(cmp_lt), .cmp_eq(cmp_eq), .max_sel(md.max_sel), .so_in(so_in),
      .pick_first(pick_first), .cond_new(cond_new));

   always_comb begin
      sel_comb = pick_first ? opa_eff : opb;
      cond_upd = in_valid && rec_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cond_q <= '0;
      else if (cond_upd)
         cond_q <= cond_new;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic            vld_q;
         logic [XLEN-1:0] res_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               res_q <= '0;
            end else begin
               vld_q <= in_valid;
               if (in_valid)
                  res_q <= sel_comb;
            end
         end

         always_comb begin
            out_valid = vld_q;
            result    = res_q;
            cond      = cond_q;
         end

         AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R9
         AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R9
         AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_valid && rec_en) |=> $stable(cond)); // R7
         AST_COND_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && rec_en) |=> (cond[0] == $past(so_in))); // R6
         AST_RESULT_IS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (result == $past(opa_eff) || result == $past(opb))); // R5
      end else begin : g_comb
         always_comb begin
            out_valid = in_valid;
            result    = sel_comb;
            cond      = cond_upd ? cond_new : cond_q;
         end

         AST_COND_HOLD_COMB: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_valid && rec_en) |=> $stable(cond_q)); // R7
         AST_RESULT_IS_SOURCE_COMB: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (result == opa_eff || result == opb)); // R5
      end
   endgenerate
endmodule

// File: tb/test_minmax_unit.sv
module test_minmax_unit;
   localparam int XLEN = 64;
   localparam int HALF = XLEN / 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [2:0]      mode = '0;
   logic            rec_en = 1'b0;
   logic            ra_zero = 1'b0;
   logic            so_in = 1'b0;
   logic [XLEN-1:0] opa = '0;
   logic [XLEN-1:0] opb = '0;
   logic            out_valid;
   logic [XLEN-1:0] result;
   logic [3:0]      cond;

   int vectors = 0;
   int errors  = 0;
   logic [3:0] cond_exp = '0;

   always #5 clk = ~clk;

   minmax_unit i_minmax_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .rec_en(rec_en),
      .ra_zero(ra_zero), .so_in(so_in), .opa(opa), .opb(opb),
      .out_valid(out_valid), .result(result), .cond(cond));

   // Reference ordering: -1 less, 0 equal, +1 greater
   function automatic int ref_order(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                    input logic [2:0] m);
      if (m[0]) begin
         if (m[1]) begin
            if ($signed(a[HALF-1:0]) < $signed(b[HALF-1:0])) return -1;
            if ($signed(a[HALF-1:0]) > $signed(b[HALF-1:0])) return 1;
         end else begin
            if (a[HALF-1:0] < b[HALF-1:0]) return -1;
            if (a[HALF-1:0] > b[HALF-1:0]) return 1;
         end
      end else begin
         if (m[1]) begin
            if ($signed(a) < $signed(b)) return -1;
            if ($signed(a) > $signed(b)) return 1;
         end else begin
            if (a < b) return -1;
            if (a > b) return 1;
         end
      end
      return 0;
   endfunction

   function automatic logic [XLEN-1:0] ref_result(input logic [XLEN-1:0] a,
      input logic [XLEN-1:0] b, input logic [2:0] m);
      int o;
      o = ref_order(a, b, m);
      if (!m[2]) return (o < 0) ? a : b;
      return (o > 0) ? a : b;
   endfunction

   function automatic logic [3:0] ref_cond(input logic [XLEN-1:0] a,
      input logic [XLEN-1:0] b, input logic [2:0] m, input logic so);
      int o;
      o = ref_order(a, b, m);
      return {o < 0, o > 0, o == 0, so};
   endfunction

   task automatic check_val(input string req, input logic [XLEN-1:0] act,
                            input logic [XLEN-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Present one vector, check it one rising edge later
   task automatic apply(input string req, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                        input logic [2:0] m, input logic rec, input logic rz, input logic so);
      logic [XLEN-1:0] ae;
      ae = rz ? '0 : a;
      in_valid = 1'b1; opa = a; opb = b; mode = m; rec_en = rec; ra_zero = rz; so_in = so;
      if (rec) cond_exp = ref_cond(ae, b, m, so);
      @(negedge clk);
      in_valid = 1'b0;
      check_val({req, " out_valid R9"}, {63'b0, out_valid}, 64'd1);
      check_val({req, " result"}, result, ref_result(ae, b, m));
      check_val({req, " cond R6/R7"}, {60'b0, cond}, {60'b0, cond_exp});
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [XLEN-1:0] ext [6];
      process::self().srandom(32'd1234);
      ext[0] = '0;
      ext[1] = '1;
      ext[2] = {1'b1, {(XLEN-1){1'b0}}};
      ext[3] = {1'b0, {(XLEN-1){1'b1}}};
      ext[4] = {{HALF{1'b0}}, 1'b1, {(HALF-1){1'b0}}};
      ext[5] = {{HALF{1'b1}}, 1'b0, {(HALF-1){1'b1}}};

      repeat (3) @(negedge clk);
      // R10 reset state
      check_val("R10 out_valid", {63'b0, out_valid}, 64'd0);
      check_val("R10 result", result, '0);
      check_val("R10 cond", {60'b0, cond}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 unsigned full width
      apply("R1 min", 64'h8000_0000_0000_0000, 64'h7, 3'b000, 1'b1, 1'b0, 1'b0);
      apply("R1 max", 64'h8000_0000_0000_0000, 64'h7, 3'b100, 1'b1, 1'b0, 1'b1);
      // R2 half-width: upper halves differ, low halves decide
      apply("R2 half min", 64'h0000_0001_0000_0009, 64'hFFFF_0000_0000_0003, 3'b001, 1'b1, 1'b0, 1'b0);
      // R3 signed
      apply("R3 signed min", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3'b010, 1'b1, 1'b0, 1'b0);
      apply("R3 signed half max", 64'h0000_0000_8000_0000, 64'h1234_0000_7FFF_FFFF, 3'b111, 1'b1, 1'b0, 1'b0);
      // R4 ties return second operand (half mode shows it)
      apply("R4 tie min", 64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 3'b001, 1'b1, 1'b0, 1'b1);
      apply("R4 tie max", 64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 3'b101, 1'b1, 1'b0, 1'b0);
      // R5 full width return in half mode
      apply("R5 full width", 64'hDEAD_BEEF_0000_0001, 64'h0123_4567_0000_0002, 3'b001, 1'b1, 1'b0, 1'b0);
      // R7 rec_en clear leaves cond unchanged
      apply("R7 no record", 64'h5, 64'h9, 3'b100, 1'b0, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      check_val("R7 cond held idle", {60'b0, cond}, {60'b0, cond_exp});
      check_val("R9 idle out_valid", {63'b0, out_valid}, 64'd0);
      // R8 zero register
      apply("R8 zero min", 64'hFFFF, 64'h3, 3'b000, 1'b1, 1'b1, 1'b0);
      apply("R8 zero signed max", 64'h7, 64'hFFFF_FFFF_FFFF_FFFE, 3'b110, 1'b1, 1'b1, 1'b0);

      // Extremes in every mode
      for (int m = 0; m < 8; m++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               apply("R1-R6 extreme", ext[i], ext[j], m[2:0], 1'b1, 1'b0, i[0]);

      // Constrained random
      for (int k = 0; k < 600; k++) begin
         logic [XLEN-1:0] a, b;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) b = a;
         if ($urandom_range(0, 3) == 0) b[HALF-1:0] = a[HALF-1:0];
         apply("R1-R8 random", a, b, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
         if ($urandom_range(0, 4) == 0) begin
            @(negedge clk);
            check_val("R9 gap out_valid", {63'b0, out_valid}, 64'd0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule